// File: doc/BRIEF.md
# Ternary Link Training Sequencer

This block steps a full-duplex ternary-signalling PHY through its start-up training, from a quiet line to an active link, in either the master or the slave role. The datapath (echo canceller, equalizer, SNR estimator, phase measurement) sits outside the block. The datapath reports to the sequencer through status inputs. The sequencer drives back transmitter enable, echo-canceller adaptation, the equalizer training mode and the sampling phase index.

On the master, the echo canceller trains for a fixed dwell and the block then waits for the far end's signal. It then sweeps every sampling phase. At each phase it takes one error value on a single-cycle strobe and keeps the smallest, and it locks the phase to the winner. Blind equalizer training follows, then decision-directed training, then link up. On the slave, the sequence is master clock acquisition with the transmitter off, then a fixed echo-canceller dwell, then the same blind and decision-directed steps. Either side leaves blind training by itself as soon as its SNR flag is set. Dropping the enable or signalling link loss returns the block to the silent state from any point.

Top module: `lt_train_seq`

## Requirements
- R1: After reset, and whenever the state is silent, tx_on=0, ec_adapt=0, eq_mode=2'b00 (off), link_up=0 and phase_idx=0. The state stays silent while link_en is low.
- R2: With link_en=1, link_loss=0 and master_role=1 sampled in silent, the next cycle has tx_on=1 and ec_adapt=1. After ECHO_CYCLES cycles of echo training the block waits, with eq_mode=00, until slave_detect is 1.
- R3: When slave_detect is seen, the sweep starts at phase_idx=0. Each phase_err_valid pulse in the sweep advances phase_idx by one on the next cycle. Pulses outside the sweep have no effect.
- R4: The pulse taken at phase N_PHASE-1 ends the sweep. phase_idx then shows the index whose 16-bit unsigned error was smallest, with a tie going to the lower index, and it holds that value through blind training, decision-directed training and link up.
- R5: With master_role=0 sampled in silent, the slave waits for clk_found with tx_on=0 and ec_adapt=0. It then has tx_on=1 and ec_adapt=1 for ECHO_CYCLES cycles of echo training before blind training. On the slave, phase_idx stays 0.
- R6: In blind training eq_mode=2'b01. The block stays there until snr_good=1, and switches to eq_mode=2'b10 (decision-directed) on the next cycle.
- R7: Decision-directed training lasts DD_CYCLES cycles, and then link_up=1. During link up, tx_on=1, ec_adapt=1 and eq_mode=2'b10 stay asserted.
- R8: link_en=0 or link_loss=1 in any state gives the silent outputs of R1 on the next cycle. A later start runs a fresh sweep that forgets earlier errors.
- R9: master_role is used only when leaving silent. A change later in the run does not alter the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Training enable; low forces silent |
| master_role | input | 1 | 1 = master path, 0 = slave path |
| slave_detect | input | 1 | Master: far-end signal seen |
| clk_found | input | 1 | Slave: master clock acquired |
| phase_err | input | ERR_W | Error measured at the current phase |
| phase_err_valid | input | 1 | One-cycle strobe for phase_err |
| snr_good | input | 1 | SNR sufficient for decision-directed mode |
| link_loss | input | 1 | Link lost; return to silent |
| phase_idx | output | $clog2(N_PHASE) | Sampling phase index |
| tx_on | output | 1 | Transmitter enabled |
| ec_adapt | output | 1 | Echo canceller adapting |
| eq_mode | output | 2 | 00 off, 01 blind, 10 decision-directed |
| link_up | output | 1 | Initial training complete |

## Verification
The bench builds the block with four phases, an echo dwell of three cycles and a decision-directed dwell of two cycles. Each full master sweep, including gaps between strobes, therefore takes only a few dozen cycles. With these values the bench can run a sweep whose best error is in the middle with a tie after it, one where all errors are equal, and one where the last phase wins. It can also abort a sweep part way and restart it, and follow the whole slave path, all against a behavioural reference that is compared on every cycle.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;

  typedef enum logic [3:0] {
    ST_SILENT  = 4'd0,
    ST_M_ECHO  = 4'd1,
    ST_M_WAIT  = 4'd2,
    ST_M_SWEEP = 4'd3,
    ST_M_BLIND = 4'd4,
    ST_M_DD    = 4'd5,
    ST_M_UP    = 4'd6,
    ST_S_ACQ   = 4'd7,
    ST_S_ECHO  = 4'd8,
    ST_S_BLIND = 4'd9,
    ST_S_DD    = 4'd10,
    ST_S_UP    = 4'd11
  } lt_state_e;

  typedef enum logic [1:0] {
    EQ_OFF   = 2'b00,
    EQ_BLIND = 2'b01,
    EQ_DD    = 2'b10
  } eq_mode_e;

endpackage

// File: rtl/lt_dwell_timer.sv
`timescale 1ns/1ps
module lt_dwell_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (!done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2 / R7: the dwell count never passes the programmed length
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit - 1'b1));

  // R2: an idle timer starts from zero
  a_r2_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/lt_phase_search.sv
`timescale 1ns/1ps
module lt_phase_search #(
  parameter int N_PHASE = 8,
  parameter int ERR_W   = 16,
  parameter int PW      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic [ERR_W-1:0] err,
  output logic [PW-1:0]    cur_phase,
  output logic [PW-1:0]    best_phase,
  output logic             last
);

  localparam logic [PW-1:0] LAST_IDX = PW'(N_PHASE - 1);

  logic [PW-1:0]    cur_q, cur_d;
  logic [PW-1:0]    best_q, best_d;
  logic [ERR_W-1:0] berr_q, berr_d;
  logic             better;

  assign last       = (cur_q == LAST_IDX);
  assign better     = (err < berr_q);
  assign cur_phase  = cur_q;
  assign best_phase = best_q;

  always_comb begin
    cur_d  = cur_q;
    best_d = best_q;
    berr_d = berr_q;
    if (clear) begin
      cur_d  = '0;
      best_d = '0;
      berr_d = '1;
    end else if (sample) begin
      if (better) begin
        best_d = cur_q;
        berr_d = err;
      end
      if (!last) cur_d = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      best_q <= '0;
      berr_q <= '1;
    end else begin
      cur_q  <= cur_d;
      best_q <= best_d;
      berr_q <= berr_d;
    end
  end

  // R3: a sample before the last phase steps the index by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !clear && !last) |=> (cur_q == $past(cur_q) + 1'b1));

  // R3: without a sample the index holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample && !clear) |=> $stable(cur_q));

  // R4: the kept minimum never rises during a sweep
  a_r4_min_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !clear) |=> (berr_q <= $past(berr_q)));

  // R4: the kept minimum is no larger than any accepted sample
  a_r4_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !clear) |=> (berr_q <= $past(err)));

endmodule

// File: rtl/lt_ctrl_fsm.sv
`timescale 1ns/1ps
module lt_ctrl_fsm
  import lt_pkg::*;
#(
  parameter int CW          = 11,
  parameter int ECHO_CYCLES = 1024,
  parameter int DD_CYCLES   = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_en,
  input  logic          master_role,
  input  logic          slave_detect,
  input  logic          clk_found,
  input  logic          snr_good,
  input  logic          link_loss,
  input  logic          err_valid,
  input  logic          sweep_last,
  input  logic          dwell_done,
  output lt_state_e     state,
  output logic          dwell_run,
  output logic [CW-1:0] dwell_limit,
  output logic          search_clear,
  output logic          search_sample,
  output logic          tx_on,
  output logic          ec_adapt,
  output logic [1:0]    eq_mode,
  output logic          link_up
);

  localparam logic [CW-1:0] ECHO_L = CW'(ECHO_CYCLES);
  localparam logic [CW-1:0] DD_L   = CW'(DD_CYCLES);

  lt_state_e state_q, state_d;
  logic      timed, dd_phase, abort;

  assign abort         = !link_en || link_loss;
  assign search_sample = err_valid && (state_q == ST_M_SWEEP);
  assign search_clear  = (state_q == ST_SILENT) || (state_q == ST_M_WAIT);

  always_comb begin
    state_d = state_q;
    if (abort) begin
      state_d = ST_SILENT;
    end else begin
      unique case (state_q)
        ST_SILENT:  state_d = master_role ? ST_M_ECHO : ST_S_ACQ;
        ST_M_ECHO:  if (dwell_done)   state_d = ST_M_WAIT;
        ST_M_WAIT:  if (slave_detect) state_d = ST_M_SWEEP;
        ST_M_SWEEP: if (search_sample && sweep_last) state_d = ST_M_BLIND;
        ST_M_BLIND: if (snr_good)     state_d = ST_M_DD;
        ST_M_DD:    if (dwell_done)   state_d = ST_M_UP;
        ST_M_UP:    state_d = ST_M_UP;
        ST_S_ACQ:   if (clk_found)    state_d = ST_S_ECHO;
        ST_S_ECHO:  if (dwell_done)   state_d = ST_S_BLIND;
        ST_S_BLIND: if (snr_good)     state_d = ST_S_DD;
        ST_S_DD:    if (dwell_done)   state_d = ST_S_UP;
        ST_S_UP:    state_d = ST_S_UP;
        default:    state_d = ST_SILENT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SILENT;
    else        state_q <= state_d;
  end

  // dwell timer control: runs only while a timed state is kept
  always_comb begin
    dd_phase    = (state_q == ST_M_DD) || (state_q == ST_S_DD);
    timed       = dd_phase || (state_q == ST_M_ECHO) || (state_q == ST_S_ECHO);
    dwell_run   = timed && (state_d == state_q);
    dwell_limit = dd_phase ? DD_L : ECHO_L;
  end

  // Moore output decode
  always_comb begin
    tx_on    = (state_q != ST_SILENT) && (state_q != ST_S_ACQ);
    ec_adapt = tx_on;
    link_up  = (state_q == ST_M_UP) || (state_q == ST_S_UP);
    unique case (state_q)
      ST_M_BLIND, ST_S_BLIND:               eq_mode = EQ_BLIND;
      ST_M_DD, ST_S_DD, ST_M_UP, ST_S_UP:   eq_mode = EQ_DD;
      default:                              eq_mode = EQ_OFF;
    endcase
  end

  assign state = state_q;

  // R8: abort request always lands in silent
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_en || link_loss) |=> (state_q == ST_SILENT));

  // R2: the master waits for the far end
  a_r2_wait_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_M_WAIT && !slave_detect && link_en && !link_loss)
      |=> (state_q == ST_M_WAIT));

  // R6: blind training is kept until the SNR flag
  a_r6_blind_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_M_BLIND || state_q == ST_S_BLIND) && !snr_good && link_en && !link_loss)
      |=> (eq_mode == EQ_BLIND));

  // R6: SNR good in blind moves to decision-directed next
  a_r6_to_dd: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_mode == EQ_BLIND && snr_good && link_en && !link_loss) |=> (eq_mode == EQ_DD));

  // R7: link up keeps every adaptation path live
  a_r7_up_live: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (tx_on && ec_adapt && eq_mode == EQ_DD));

  // R5: slave stays quiet while acquiring the clock
  a_r5_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_S_ACQ) |-> (!tx_on && eq_mode == EQ_OFF));

  // R1: no reserved equalizer code
  a_r1_eq_legal: assert property (@(posedge clk) disable iff (!rst_n)
    eq_mode != 2'b11);

endmodule

// File: rtl/lt_train_seq.sv
`timescale 1ns/1ps
module lt_train_seq
  import lt_pkg::*;
#(
  parameter int N_PHASE     = 8,
  parameter int ERR_W       = 16,
  parameter int ECHO_CYCLES = 1024,
  parameter int DD_CYCLES   = 512,
  localparam int PW         = (N_PHASE > 1) ? $clog2(N_PHASE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_en,
  input  logic             master_role,
  input  logic             slave_detect,
  input  logic             clk_found,
  input  logic [ERR_W-1:0] phase_err,
  input  logic             phase_err_valid,
  input  logic             snr_good,
  input  logic             link_loss,
  output logic [PW-1:0]    phase_idx,
  output logic             tx_on,
  output logic             ec_adapt,
  output logic [1:0]       eq_mode,
  output logic             link_up
);

  localparam int MAXC = (ECHO_CYCLES > DD_CYCLES) ? ECHO_CYCLES : DD_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  lt_state_e     state;
  logic          dwell_run, dwell_done;
  logic [CW-1:0] dwell_limit;
  logic          search_clear, search_sample, sweep_last;
  logic [PW-1:0] cur_phase, best_phase;

  lt_ctrl_fsm #(
    .CW          (CW),
    .ECHO_CYCLES (ECHO_CYCLES),
    .DD_CYCLES   (DD_CYCLES)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_en       (link_en),
    .master_role   (master_role),
    .slave_detect  (slave_detect),
    .clk_found     (clk_found),
    .snr_good      (snr_good),
    .link_loss     (link_loss),
    .err_valid     (phase_err_valid),
    .sweep_last    (sweep_last),
    .dwell_done    (dwell_done),
    .state         (state),
    .dwell_run     (dwell_run),
    .dwell_limit   (dwell_limit),
    .search_clear  (search_clear),
    .search_sample (search_sample),
    .tx_on         (tx_on),
    .ec_adapt      (ec_adapt),
    .eq_mode       (eq_mode),
    .link_up       (link_up)
  );

  lt_dwell_timer #(.CW(CW)) u_dwell (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (dwell_run),
    .limit (dwell_limit),
    .done  (dwell_done)
  );

  lt_phase_search #(
    .N_PHASE (N_PHASE),
    .ERR_W   (ERR_W),
    .PW      (PW)
  ) u_search (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (search_clear),
    .sample     (search_sample),
    .err        (phase_err),
    .cur_phase  (cur_phase),
    .best_phase (best_phase),
    .last       (sweep_last)
  );

  // phase select: sweep shows the probe, later master states the winner
  always_comb begin
    unique case (state)
      ST_M_SWEEP:                    phase_idx = cur_phase;
      ST_M_BLIND, ST_M_DD, ST_M_UP:  phase_idx = best_phase;
      default:                       phase_idx = '0;
    endcase
  end

  // R4: the locked phase holds through decision-directed training and link up
  a_r4_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_M_DD || state == ST_M_UP) |-> $stable(phase_idx));

  // R5: slave path never moves the phase
  a_r5_slave_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_S_ACQ, ST_S_ECHO, ST_S_BLIND, ST_S_DD, ST_S_UP}) |-> (phase_idx == '0));

  // R3: the sweep opens at phase zero
  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_M_WAIT && slave_detect && link_en && !link_loss) |=> (phase_idx == '0));

endmodule

// File: tb/lt_train_seq_tb.sv
`timescale 1ns/1ps
module lt_train_seq_tb;

  localparam int NP   = 4;
  localparam int ECHO = 3;
  localparam int DD   = 2;
  localparam int PW   = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic link_en, master_role, slave_detect, clk_found;
  logic [15:0] phase_err;
  logic phase_err_valid, snr_good, link_loss;
  logic [PW-1:0] phase_idx;
  logic tx_on, ec_adapt, link_up;
  logic [1:0] eq_mode;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lt_train_seq #(
    .N_PHASE(NP), .ERR_W(16), .ECHO_CYCLES(ECHO), .DD_CYCLES(DD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .master_role(master_role),
    .slave_detect(slave_detect), .clk_found(clk_found), .phase_err(phase_err),
    .phase_err_valid(phase_err_valid), .snr_good(snr_good), .link_loss(link_loss),
    .phase_idx(phase_idx), .tx_on(tx_on), .ec_adapt(ec_adapt),
    .eq_mode(eq_mode), .link_up(link_up)
  );

  // ---------------- behavioural reference ----------------
  // 0 silent,1 m-echo,2 m-wait,3 m-sweep,4 m-blind,5 m-dd,6 m-up,
  // 7 s-acq,8 s-echo,9 s-blind,10 s-dd,11 s-up
  int ms, mcnt, mcur, mbest, mberr;

  always @(posedge clk or negedge rst_n) begin
    int nxt;
    if (!rst_n) begin
      ms = 0; mcnt = 0; mcur = 0; mbest = 0; mberr = 65535;
    end else begin
      nxt = ms;
      if (!link_en || link_loss) nxt = 0;
      else case (ms)
        0:  nxt = master_role ? 1 : 7;
        1:  if (mcnt == ECHO-1) nxt = 2;
        2:  if (slave_detect) nxt = 3;
        3:  if (phase_err_valid && mcur == NP-1) nxt = 4;
        4:  if (snr_good) nxt = 5;
        5:  if (mcnt == DD-1) nxt = 6;
        7:  if (clk_found) nxt = 8;
        8:  if (mcnt == ECHO-1) nxt = 9;
        9:  if (snr_good) nxt = 10;
        10: if (mcnt == DD-1) nxt = 11;
        default: ;
      endcase
      if (ms == 0 || ms == 2) begin
        mcur = 0; mbest = 0; mberr = 65535;
      end else if (ms == 3 && phase_err_valid) begin
        if (int'(phase_err) < mberr) begin mberr = int'(phase_err); mbest = mcur; end
        if (mcur < NP-1) mcur = mcur + 1;
      end
      if (nxt != ms) mcnt = 0;
      else if (ms == 1 || ms == 5 || ms == 8 || ms == 10) mcnt = mcnt + 1;
      ms = nxt;
    end
  end

  function automatic logic [6:0] exp_out();
    logic [PW-1:0] p;
    logic t, u;
    logic [1:0] q;
    t = (ms != 0 && ms != 7);
    u = (ms == 6 || ms == 11);
    q = (ms == 4 || ms == 9) ? 2'b01 :
        (ms == 5 || ms == 6 || ms == 10 || ms == 11) ? 2'b10 : 2'b00;
    p = (ms == 3) ? PW'(mcur) : (ms >= 4 && ms <= 6) ? PW'(mbest) : '0;
    return {p, t, t, q, u};
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R1";
      1, 2: return "R2";
      3: return "R3";
      4, 9: return "R6";
      5, 6, 10, 11: return "R7";
      default: return "R5";
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [6:0] act, ex;
    if (rst_n === 1'b1 && !finished) begin
      act = {phase_idx, tx_on, ec_adapt, eq_mode, link_up};
      ex  = exp_out();
      total++;
      if (act !== ex) begin
        bad++;
        $display("FAIL %s cycle %0d: outputs act=%h exp=%h", tag_of(ms), cycles, act, ex);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int e);
    @(negedge clk);
    phase_err = 16'(e);
    phase_err_valid = 1'b1;
    @(negedge clk);
    phase_err_valid = 1'b0;
    tick(1);
  endtask

  task automatic wait_up();
    int k = 0;
    while (link_up !== 1'b1 && k < 100) begin tick(1); k++; end
  endtask

  task automatic to_sweep();
    link_en = 1; master_role = 1;
    tick(ECHO + 2);
    slave_detect = 1;
    tick(1);
  endtask

  task automatic finish_train();
    tick(3);
    snr_good = 1;
    wait_up();
    snr_good = 0;
  endtask

  task automatic stop_link();
    link_en = 0; slave_detect = 0; clk_found = 0;
    tick(2);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; link_en = 0; master_role = 0; slave_detect = 0; clk_found = 0;
    phase_err = '0; phase_err_valid = 0; snr_good = 0; link_loss = 0;
    tick(3);
    rst_n = 1;
    tick(2);
    // R1: reset state
    chk(!tx_on && !link_up && eq_mode == 2'b00 && phase_idx == 0, "R1", int'(tx_on), 0);
    link_loss = 1; tick(2); link_loss = 0;

    // master run 1: strobe in wait ignored, tie after a minimum, role change mid-run
    link_en = 1; master_role = 1;
    tick(1);
    chk(tx_on && ec_adapt, "R2", int'(tx_on), 1);
    tick(ECHO + 1);
    strobe(10);
    chk(tx_on && eq_mode == 2'b00 && !link_up, "R2", int'(eq_mode), 0);
    slave_detect = 1;
    tick(1);
    chk(phase_idx == 0, "R3", int'(phase_idx), 0);
    strobe(500);
    chk(phase_idx == 1, "R3", int'(phase_idx), 1);
    master_role = 0;
    strobe(200); strobe(200); strobe(900);
    chk(phase_idx == 1 && eq_mode == 2'b01, "R4", int'(phase_idx), 1);
    strobe(0);
    chk(phase_idx == 1, "R4", int'(phase_idx), 1);
    finish_train();
    chk(link_up && phase_idx == 1, "R9", int'(phase_idx), 1);
    link_loss = 1; tick(1); link_loss = 0;
    chk(!tx_on && !link_up && phase_idx == 0, "R8", int'(tx_on), 0);
    stop_link();

    // master run 2: all errors equal -> phase 0
    to_sweep();
    strobe(300); strobe(300); strobe(300); strobe(300);
    finish_train();
    chk(link_up && phase_idx == 0, "R4", int'(phase_idx), 0);
    stop_link();

    // master run 3: aborted part way, restart, last phase wins
    to_sweep();
    strobe(1); strobe(2);
    link_en = 0; tick(1);
    chk(!tx_on && phase_idx == 0, "R8", int'(phase_idx), 0);
    slave_detect = 0;
    to_sweep();
    chk(phase_idx == 0, "R8", int'(phase_idx), 0);
    strobe(900); strobe(800); strobe(700); strobe(50);
    finish_train();
    chk(link_up && phase_idx == 3, "R4", int'(phase_idx), 3);
    stop_link();

    // slave run
    link_en = 1; master_role = 0;
    tick(4);
    chk(!tx_on && !ec_adapt, "R5", int'(tx_on), 0);
    strobe(5);
    clk_found = 1;
    tick(1);
    chk(tx_on && ec_adapt && eq_mode == 2'b00, "R5", int'(tx_on), 1);
    tick(ECHO);
    chk(eq_mode == 2'b01, "R6", int'(eq_mode), 1);
    tick(1);
    snr_good = 1; tick(1); snr_good = 0;
    chk(eq_mode == 2'b10 && !link_up, "R6", int'(eq_mode), 2);
    tick(DD);
    chk(link_up && phase_idx == 0, "R7", int'(link_up), 1);
    link_en = 0; tick(1);
    chk(!link_up && !tx_on, "R8", int'(link_up), 0);
    stop_link();

    // slave abort during clock acquisition
    link_en = 1; tick(3);
    link_loss = 1; tick(1);
    chk(!tx_on && eq_mode == 2'b00, "R8", int'(tx_on), 0);
    link_loss = 0; link_en = 0;
    tick(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule